// File: doc/BRIEF.md
# Prescaled Capture Timer

A 16-bit up-counter that software can read but never load, driven through a small prescaler. The prescaler takes its events from one of three places: a tick that fires once every twelve system clocks, rising edges on an external clock pin, or nothing at all. It passes on one increment per 1, 2, 4 or 8 events. The counter returns to zero on system reset or on a rising edge of an external clear pin, if that clear is enabled. While the idle input is high, the counter and the prescaler are held at zero.

Four capture channels watch their own input pins. Each pin passes through a two-flop synchronizer before its edges are detected. Each channel can be set to react to rising edges, falling edges, both, or neither. On a selected edge the channel copies the live count into its own register and sets its flag. Two further flags record a wrap of the low byte and a wrap of the full 16 bits. Either or both of them can be routed onto a single request output. Software clears every flag by writing ones to the flag register.

Top module: `capt_timer`

## Requirements
- R1: CONF[1:0] selects the event source. 1 gives one event every 12 clocks. 2 gives one event per synchronized rising edge of `ext_clk`. 0 and 3 give no events, so the count holds.
- R2: CONF[3:2] = s makes the count advance once per 2^s events (1, 2, 4 or 8).
- R3: A write to CONF that changes bits [3:0] clears the prescaler's event tally. A rising edge on `ext_clr` that clears the counter also clears the tally. Rewriting the same value has no effect on the tally.
- R4: The count cannot be written: writes to addresses 3 and 4 leave it unchanged. It is zero after reset. When CONF[4]=1, a synchronized rising edge of `ext_clr` sets it to zero. When CONF[4]=0, that edge is ignored.
- R5: While `idle` is 1, the count and the prescaler are held at zero and no event advances them.
- R6: EDGE (address 1) holds bits [2k+1:2k] for channel k: bit 2k selects the rising edge and bit 2k+1 selects the falling edge. With both bits zero, the channel never captures and never sets its flag.
- R7: A selected edge copies the count into channel k's register, at addresses 8+2k (low byte) and 9+2k (high byte), and sets FLAGS[k]. The copy takes the count value of the third clock after the pin changes.
- R8: When the count steps from xxFF, FLAGS[4] is set. When it steps from FFFF to 0000, FLAGS[5] is set as well.
- R9: `irq` = (FLAGS[4] & CONF[5]) | (FLAGS[5] & CONF[6]).
- R10: A flag clears only when software writes a 1 to its bit at address 2. Writing 0 leaves it set. If the flag is set in the same cycle as the clear, the set wins.
- R11: Addresses 3 and 4 return the live low and high count bytes in the cycle they are addressed. The high byte is not latched when the low byte is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| idle | input | 1 | Holds counter and prescaler at zero |
| ext_clk | input | 1 | External count-event pin |
| ext_clr | input | 1 | External counter-clear pin |
| cap_in | input | 4 | Capture pins, one per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| cap_flag | output | 4 | Per-channel capture flags |
| ovf_flag | output | 2 | [0] low-byte wrap, [1] full wrap |
| irq | output | 1 | Shared overflow request |

## Verification
A wrong prescaler tally appears at the count bytes only after enough further events to complete a division cycle. The bench therefore counts exact edge numbers across each division change, and checks both just before and just after the expected increment. A bad synchronizer depth or edge decode shows up within a few clocks as a wrong capture value or a wrong flag. The reference model compares the flags and the request output on every clock. A wrong wrap detector only shows up after 256 or 65536 events, so the bench drives the count through both boundaries.

// File: rtl/ct_pkg.sv
package ct_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_TICK = 2'd1,
    SRC_PIN  = 2'd2,
    SRC_NIL  = 2'd3
  } src_e;

  // configuration register, bit 6 down to bit 0
  typedef struct packed {
    logic       full_en;
    logic       low_en;
    logic       xclr_en;
    logic [1:0] div_sel;
    src_e       src;
  } conf_t;

  localparam int unsigned ADR_CONF  = 0;
  localparam int unsigned ADR_EDGE  = 1;
  localparam int unsigned ADR_FLAGS = 2;
  localparam int unsigned ADR_CNT   = 3;
  localparam int unsigned ADR_CAP   = 8;

endpackage

// File: rtl/ct_sync_edge.sv
module ct_sync_edge (
  input  logic clk,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);

  logic [2:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  // sh_q[1] is the synchronized level, sh_q[2] its previous value
  assign rise_o = sh_q[1] & ~sh_q[2];
  assign fall_o = ~sh_q[1] & sh_q[2];

endmodule

// File: rtl/ct_prescale.sv
module ct_prescale #(
  parameter int unsigned TICK_DIV = 12,
  parameter int unsigned DSW      = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  ct_pkg::src_e     src_i,
  input  logic [DSW-1:0]   div_sel_i,
  input  logic             pin_rise_i,
  input  logic             clr_i,
  output logic             inc_o
);
  import ct_pkg::*;

  localparam int unsigned TKW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned PW  = (1 << DSW) - 1;
  localparam logic [TKW-1:0] TK_LAST = TKW'(TICK_DIV - 1);

  logic [TKW-1:0] tk_q, tk_d;
  logic [PW-1:0]  pc_q, pc_d;
  logic [PW-1:0]  mask;
  logic           tick, ev, full;

  always_comb begin
    tick = (tk_q == TK_LAST);
    tk_d = tick ? '0 : tk_q + TKW'(1);
    ev   = ((src_i == SRC_TICK) && tick) || ((src_i == SRC_PIN) && pin_rise_i);
    mask = ~({PW{1'b1}} << div_sel_i);
    full = ((pc_q & mask) == mask);
    inc_o = ev && full && !clr_i;
    if (clr_i)   pc_d = '0;
    else if (ev) pc_d = full ? '0 : pc_q + PW'(1);
    else         pc_d = pc_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tk_q <= '0;
      pc_q <= '0;
    end else begin
      tk_q <= tk_d;
      pc_q <= pc_d;
    end
  end

  AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_i |=> (pc_q == '0)); // R3

  AST_PRE_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_ni)
    (tk_q == TK_LAST) |=> (tk_q == '0)); // R1

endmodule

// File: rtl/ct_capture_ch.sv
module ct_capture_ch #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [1:0]    sel_i,
  input  logic [TW-1:0] cnt_i,
  input  logic          clr_i,
  output logic [TW-1:0] cap_o,
  output logic          flag_o
);

  logic [TW-1:0] cap_q, cap_d;
  logic          flag_q, flag_d;
  logic          hit;

  always_comb begin
    hit    = (rise_i && sel_i[0]) || (fall_i && sel_i[1]);
    cap_d  = hit ? cnt_i : cap_q;
    flag_d = hit || (flag_q && !clr_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      flag_q <= flag_d;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;

  AST_CAP_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(rise_i || fall_i)); // R7

  AST_CAP_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_ni)
    (sel_i == 2'b00) |=> (cap_q == $past(cap_q))); // R6

endmodule

// File: rtl/capt_timer.sv
module capt_timer #(
  parameter int unsigned TW       = 16,
  parameter int unsigned NCAP     = 4,
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 4,
  parameter int unsigned TICK_DIV = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle,
  input  logic            ext_clk,
  input  logic            ext_clr,
  input  logic [NCAP-1:0] cap_in,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [NCAP-1:0] cap_flag,
  output logic [1:0]      ovf_flag,
  output logic            irq
);
  import ct_pkg::*;

  localparam int unsigned NBYTE = TW / DW;
  localparam int unsigned FW    = NCAP + 2;
  localparam int unsigned EW    = 2 * NCAP;
  localparam int unsigned CW    = $bits(conf_t);

  // reset: asserted at once, released after two clocks
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // register file state
  conf_t          conf_q, conf_d;
  logic [EW-1:0]  edge_q, edge_d;
  logic [TW-1:0]  cnt_q, cnt_d;
  logic [1:0]     ovf_q, ovf_d;

  logic           wr_conf, wr_edge, wr_flags;
  logic [FW-1:0]  flag_clr;
  logic           conf_chg, xclr_ev, pre_clr, inc;
  logic           low_wrap, full_wrap;
  logic           pin_rise, pin_fall_nc, xclr_rise, xclr_fall_nc;
  logic [NCAP-1:0] c_rise, c_fall;
  logic [TW-1:0]  cap_w [NCAP];

  ct_sync_edge u_pin (
    .clk(clk), .rst_ni(rst_i), .d_i(ext_clk),
    .rise_o(pin_rise), .fall_o(pin_fall_nc)
  );

  ct_sync_edge u_xclr (
    .clk(clk), .rst_ni(rst_i), .d_i(ext_clr),
    .rise_o(xclr_rise), .fall_o(xclr_fall_nc)
  );

  always_comb begin
    wr_conf  = wr_en && (addr == AW'(ADR_CONF));
    wr_edge  = wr_en && (addr == AW'(ADR_EDGE));
    wr_flags = wr_en && (addr == AW'(ADR_FLAGS));
    flag_clr = wr_flags ? wdata[FW-1:0] : '0;
    conf_chg = wr_conf && (wdata[3:0] != {conf_q.div_sel, conf_q.src});
    xclr_ev  = conf_q.xclr_en && xclr_rise;
    pre_clr  = idle || xclr_ev || conf_chg;
  end

  ct_prescale #(.TICK_DIV(TICK_DIV), .DSW(2)) u_pre (
    .clk(clk), .rst_ni(rst_i),
    .src_i(conf_q.src), .div_sel_i(conf_q.div_sel),
    .pin_rise_i(pin_rise), .clr_i(pre_clr), .inc_o(inc)
  );

  // counter, overflow flags and configuration: next state
  always_comb begin
    low_wrap  = inc && (cnt_q[DW-1:0] == {DW{1'b1}});
    full_wrap = inc && (cnt_q == {TW{1'b1}});
    if (idle || xclr_ev) cnt_d = '0;
    else if (inc)        cnt_d = cnt_q + TW'(1);
    else                 cnt_d = cnt_q;
    ovf_d[0] = low_wrap  || (ovf_q[0] && !flag_clr[NCAP]);
    ovf_d[1] = full_wrap || (ovf_q[1] && !flag_clr[NCAP+1]);
    conf_d   = wr_conf ? conf_t'(wdata[CW-1:0]) : conf_q;
    edge_d   = wr_edge ? wdata[EW-1:0] : edge_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      conf_q <= '0;
      edge_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= '0;
    end else begin
      conf_q <= conf_d;
      edge_q <= edge_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  // capture channels
  for (genvar k = 0; k < NCAP; k++) begin : g_ch
    ct_sync_edge u_sync (
      .clk(clk), .rst_ni(rst_i), .d_i(cap_in[k]),
      .rise_o(c_rise[k]), .fall_o(c_fall[k])
    );
    ct_capture_ch #(.TW(TW)) u_ch (
      .clk(clk), .rst_ni(rst_i),
      .rise_i(c_rise[k]), .fall_i(c_fall[k]),
      .sel_i(edge_q[2*k +: 2]), .cnt_i(cnt_q),
      .clr_i(flag_clr[k]),
      .cap_o(cap_w[k]), .flag_o(cap_flag[k])
    );
  end

  // read path: live values, no holding register
  always_comb begin
    rdata = '0;
    if (addr == AW'(ADR_CONF))  rdata = DW'(conf_q);
    if (addr == AW'(ADR_EDGE))  rdata = DW'(edge_q);
    if (addr == AW'(ADR_FLAGS)) rdata = DW'({ovf_q, cap_flag});
    for (int b = 0; b < NBYTE; b++) begin
      if (addr == AW'(ADR_CNT + b)) rdata = cnt_q[b*DW +: DW];
    end
    for (int k = 0; k < NCAP; k++) begin
      for (int b = 0; b < NBYTE; b++) begin
        if (addr == AW'(ADR_CAP + k*NBYTE + b)) rdata = cap_w[k][b*DW +: DW];
      end
    end
  end

  assign ovf_flag = ovf_q;
  assign irq      = (ovf_q[0] && conf_q.low_en) || (ovf_q[1] && conf_q.full_en);

  AST_IDLE_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_i)
    idle |=> (cnt_q == '0)); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_i)
    1'b1 |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + TW'(1)) || (cnt_q == '0))); // R4

  AST_FULL_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_i)
    full_wrap |=> (ovf_q[1] && ovf_q[0])); // R8

  AST_LOW_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(ovf_q[0]) |-> $past(wr_en && (addr == AW'(ADR_FLAGS)) && wdata[NCAP])); // R10

  AST_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_i)
    irq |-> (ovf_q[0] || ovf_q[1])); // R9

endmodule

// File: tb/sim_capt_timer.sv
`timescale 1ns/1ps
module sim_capt_timer;

  logic       clk = 1'b0;
  logic       rst_n, idle, ext_clk, ext_clr, wr_en;
  logic [3:0] cap_in, addr;
  logic [7:0] wdata, rdata;
  logic [3:0] cap_flag;
  logic [1:0] ovf_flag;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  capt_timer u0 (
    .clk(clk), .rst_n(rst_n), .idle(idle), .ext_clk(ext_clk), .ext_clr(ext_clr),
    .cap_in(cap_in), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .cap_flag(cap_flag), .ovf_flag(ovf_flag), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [1:0] m_rp;
  logic [2:0] m_pin, m_xc;
  logic [2:0] m_cs [4];
  int         m_tk, m_pc, m_cnt;
  logic [6:0] m_conf;
  logic [7:0] m_edge;
  int         m_cap [4];
  logic [3:0] m_cf;
  logic [1:0] m_of;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rp = 0; m_pin = 0; m_xc = 0; m_tk = 0; m_pc = 0; m_cnt = 0;
      m_conf = 0; m_edge = 0; m_cf = 0; m_of = 0;
      for (int k = 0; k < 4; k++) begin m_cs[k] = 0; m_cap[k] = 0; end
    end else begin
      if (!m_rp[1]) begin
        m_pin = 0; m_xc = 0; m_tk = 0; m_pc = 0; m_cnt = 0;
        m_conf = 0; m_edge = 0; m_cf = 0; m_of = 0;
        for (int k = 0; k < 4; k++) begin m_cs[k] = 0; m_cap[k] = 0; end
      end else begin
        bit p_r, x_r, tick, ev, xr, chg, inc, lw, fw;
        int old, dv;
        logic [7:0] clr;
        p_r  = m_pin[1] & ~m_pin[2];
        x_r  = m_xc[1] & ~m_xc[2];
        tick = (m_tk == 11);
        m_tk = tick ? 0 : m_tk + 1;
        dv   = 1 << m_conf[3:2];
        ev   = (m_conf[1:0] == 2'd1 && tick) || (m_conf[1:0] == 2'd2 && p_r);
        xr   = m_conf[4] && x_r;
        chg  = wr_en && addr == 4'd0 && wdata[3:0] != m_conf[3:0];
        clr  = (wr_en && addr == 4'd2) ? wdata : 8'h00;
        old  = m_cnt; inc = 0; lw = 0; fw = 0;
        if (idle || xr) begin m_pc = 0; m_cnt = 0; end
        else if (chg) m_pc = 0;
        else if (ev) begin
          if (m_pc + 1 >= dv) begin m_pc = 0; inc = 1; end
          else m_pc = m_pc + 1;
        end
        if (inc) begin
          lw = ((old & 255) == 255);
          fw = (old == 65535);
          m_cnt = (old + 1) & 65535;
        end
        for (int k = 0; k < 4; k++) begin
          bit r, f, h;
          r = m_cs[k][1] & ~m_cs[k][2];
          f = ~m_cs[k][1] & m_cs[k][2];
          h = (r && m_edge[2*k]) || (f && m_edge[2*k+1]);
          if (h) m_cap[k] = old;
          m_cf[k] = h || (m_cf[k] && !clr[k]);
          m_cs[k] = {m_cs[k][1:0], cap_in[k]};
        end
        m_of[0] = lw || (m_of[0] && !clr[4]);
        m_of[1] = fw || (m_of[1] && !clr[5]);
        if (wr_en && addr == 4'd0) m_conf = wdata[6:0];
        if (wr_en && addr == 4'd1) m_edge = wdata;
        m_pin = {m_pin[1:0], ext_clk};
        m_xc  = {m_xc[1:0], ext_clr};
      end
      m_rp = {m_rp[0], 1'b1};
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the flag and request outputs
  always @(negedge clk) begin
    check("R7 capture flags vs model", int'(cap_flag), int'(m_cf));
    check("R8 overflow flags vs model", int'(ovf_flag), int'(m_of));
    check("R9 request vs model", int'(irq),
          int'((m_of[0] & m_conf[5]) | (m_of[1] & m_conf[6])));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 0; wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk); addr = a; #1 v = int'(rdata);
  endtask

  task automatic rd_cnt(output int v);
    int lo, hi;
    @(negedge clk);
    addr = 4'd3; #1 lo = int'(rdata);
    addr = 4'd4; #1 hi = int'(rdata);
    v = hi * 256 + lo;
  endtask

  task automatic chk_cnt(input string tag, input int exp);
    int v;
    rd_cnt(v);
    check(tag, v, exp);
    check({tag, " (model)"}, v, m_cnt);
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input int exp);
    int v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk = 1;
      @(negedge clk); ext_clk = 0;
    end
    cyc(4);
  endtask

  task automatic clr_pulse();
    @(negedge clk); ext_clr = 1;
    @(negedge clk); ext_clr = 0;
    cyc(4);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int a, b, v;
    rst_n = 0; idle = 0; ext_clk = 0; ext_clr = 0; cap_in = 0;
    wr_en = 0; addr = 0; wdata = 0;
    cyc(5); rst_n = 1; cyc(4);

    // reset state
    chk_cnt("R4 count zero after reset", 0);
    chk_reg("R10 flags clear after reset", 4'd2, 0);

    // pin source, divide by 1, external clear enabled
    wr(4'd0, 8'h12);
    pulses(20);
    chk_cnt("R1 pin edges counted", 20);

    // source off (0 and 3)
    wr(4'd0, 8'h10); pulses(5);
    chk_cnt("R1 source 0 counts nothing", 20);
    wr(4'd0, 8'h13); pulses(5);
    chk_cnt("R1 source 3 counts nothing", 20);

    // not loadable
    wr(4'd0, 8'h12);
    wr(4'd3, 8'hAA); wr(4'd4, 8'h55); cyc(2);
    chk_cnt("R4 count writes ignored", 20);

    // external clear enabled / disabled
    clr_pulse();
    chk_cnt("R4 external clear enabled", 0);
    wr(4'd0, 8'h02); pulses(7);
    clr_pulse();
    chk_cnt("R4 external clear disabled ignored", 7);

    // prescaler clearing on setup change
    wr(4'd0, 8'h1E); clr_pulse();
    pulses(5);
    chk_cnt("R2 div8 below eight events", 0);
    wr(4'd0, 8'h1A);
    pulses(3);
    chk_cnt("R3 tally cleared on div change", 0);
    pulses(1);
    chk_cnt("R2 div4 fourth event", 1);
    pulses(2); wr(4'd0, 8'h1A); pulses(2);
    chk_cnt("R3 same value keeps tally", 2);
    wr(4'd0, 8'h1E); pulses(16);
    chk_cnt("R2 div8 sixteen events", 4);
    wr(4'd0, 8'h16); pulses(6);
    chk_cnt("R2 div2 six events", 7);

    // system tick source
    wr(4'd0, 8'h11); clr_pulse();
    rd_cnt(a); cyc(119); rd_cnt(b);
    check("R1 tick source one per twelve clocks", b - a, 10);

    // idle hold
    @(negedge clk); idle = 1;
    cyc(3);
    chk_cnt("R5 idle clears count", 0);
    wr(4'd0, 8'h12); pulses(4);
    chk_cnt("R5 idle blocks events", 0);
    @(negedge clk); idle = 0;
    pulses(3);
    chk_cnt("R5 counting resumes after idle", 3);

    // captures: ch0 rise, ch1 fall, ch2 both, ch3 none
    wr(4'd0, 8'h11);
    wr(4'd1, 8'h39);
    cyc(50);
    @(negedge clk); cap_in = 4'hF;
    cyc(30);
    @(negedge clk); cap_in = 4'h0;
    cyc(6);
    chk_reg("R6 R7 flags per edge select", 4'd2, 8'h07);
    for (int k = 0; k < 4; k++) begin
      int lo, hi;
      rd(4'(8 + 2*k), lo); rd(4'(9 + 2*k), hi);
      check($sformatf("R7 capture value ch%0d", k), hi * 256 + lo, m_cap[k]);
    end
    rd(4'd8, a); rd(4'd10, b);
    check("R7 ch1 captured later than ch0", int'(b > a), 1);
    rd(4'd14, v);
    check("R6 unselected channel never captures", v, 0);

    // flag clearing
    wr(4'd2, 8'h00);
    chk_reg("R10 writing zero keeps flags", 4'd2, 8'h07);
    wr(4'd2, 8'h01);
    chk_reg("R10 write one clears bit", 4'd2, 8'h06);
    wr(4'd2, 8'h0F);
    chk_reg("R10 all capture flags cleared", 4'd2, 8'h00);

    // low-byte wrap, live read
    wr(4'd0, 8'h32); clr_pulse();
    pulses(255);
    chk_reg("R11 low byte live at FF", 4'd3, 8'hFF);
    check("R9 no request before wrap", int'(irq), 0);
    pulses(1);
    chk_reg("R11 high byte live after carry", 4'd4, 8'h01);
    chk_reg("R11 low byte live after carry", 4'd3, 8'h00);
    chk_reg("R8 low-byte wrap flag", 4'd2, 8'h10);
    check("R9 request from low wrap", int'(irq), 1);
    wr(4'd2, 8'h10);
    check("R9 request drops on clear", int'(irq), 0);

    // full wrap with only full enabled
    wr(4'd0, 8'h52);
    pulses(65279);
    chk_cnt("R8 count at all ones", 65535);
    check("R9 low wrap masked", int'(irq), 0);
    check("R8 low flag set by earlier wraps", int'(ovf_flag[0]), 1);
    pulses(1);
    chk_cnt("R8 count wraps to zero", 0);
    chk_reg("R8 full and low wrap flags", 4'd2, 8'h30);
    check("R9 request from full wrap", int'(irq), 1);

    finish_run();
  end

endmodule